// File: doc/BRIEF.md
# Jump-Table Branch Sequencer

This unit executes a relative branch through a table of signed halfword offsets. When an instruction word carrying its opcode is presented with a start strobe, it captures the current program counter and the index register field. It then reads the index register value and forms a table address. That address is the address of the next halfword (PC + 2) plus twice the index value.

The unit issues a single halfword read on a request/response memory port, holding the request until the response is valid. It sign-extends the returned halfword, doubles it and adds it to PC + 2. It then presents the result with a one-cycle PC-load strobe and a done pulse. It is used as a multi-cycle helper beside an instruction pipeline. The pipeline stalls on the busy output and takes the new program counter when the strobe fires. All arithmetic wraps modulo 2^32, and no flags are touched.

Top module: `tblBranchSeq`

## Requirements
- R1: Out of reset, busy, memReq, pcLoad and done are all low.
- R2: A start is accepted only when busy is low and bits 15:5 of instrWord equal 11'b00000000010 (bits 4:0 name the index register). Any other word leaves busy, memReq and pcLoad low.
- R3: While memReq is high, memAddr equals (pcIn + 2) + (idxVal << 1), modulo 2^32.
- R4: pcOut during the pcLoad cycle equals (pcIn + 2) + (sign-extended memData[15:0] << 1), modulo 2^32. Negative offsets are included.
- R5: With memValid returned in the first request cycle, pcLoad is high in the 5th cycle after the cycle in which start was sampled. Each cycle that memReq waits without memValid adds one cycle.
- R6: busy is high from the cycle after an accepted start up to and including the pcLoad cycle, and it is low in the cycle after pcLoad. A start seen while busy is ignored and does not change the result.
- R7: Once memReq rises, it stays high with memAddr unchanged until a cycle in which memValid is high.
- R8: regSel equals instrWord[4:0] of the accepted word and stays constant while busy.
- R9: pcLoad and done rise together and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction word valid strobe |
| instrWord | input | 16 | Instruction word to decode |
| pcIn | input | 32 | Address of the instruction |
| idxVal | input | 32 | Value of the register named by regSel, sampled one cycle after acceptance |
| regSel | output | 5 | Index register number for the register file |
| memReq | output | 1 | Halfword read request |
| memAddr | output | 32 | Table entry address |
| memValid | input | 1 | Read response valid |
| memData | input | 16 | Read response halfword |
| busy | output | 1 | Operation in progress |
| pcLoad | output | 1 | Load pcOut into the program counter |
| pcOut | output | 32 | New program counter |
| done | output | 1 | Operation complete pulse |

## Verification
The bench builds the unit with its default widths: a 32-bit address path, 16-bit words and a 5-bit register field. These widths let it drive a program counter at 0xFFFFFFFE and an index with the top bit set, so both wrap-around sums are exercised. Halfword values 0x8000 and 0xFFF0 exercise the most negative and small negative offsets. Response delays of zero, one and three cycles reach both the minimum latency and the hold behaviour of the request.

// File: rtl/tblBranchPkg.sv
package tblBranchPkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_ADR  = 3'd2,
    ST_REQ  = 3'd3,
    ST_ADD  = 3'd4,
    ST_LD   = 3'd5
  } seqState_t;

  // Strobes from control to datapath, one per register group.
  typedef struct packed {
    logic latchInstr;
    logic latchIdx;
    logic latchAddr;
    logic latchData;
    logic latchPc;
  } dpCtl_t;

endpackage

// File: rtl/tblBranchCtrl.sv
module tblBranchCtrl
  import tblBranchPkg::*;
#(
  parameter int OPC_W = 11,
  parameter logic [OPC_W-1:0] OPC_PAT = 11'b00000000010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcField,
  input  logic             memValid,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             memReq,
  output logic             pcLoad,
  output logic             done
);

  seqState_t state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && start && (opcField == OPC_PAT);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = ST_DEC;
      ST_DEC:  stateNext = ST_ADR;
      ST_ADR:  stateNext = ST_REQ;
      ST_REQ:  if (memValid) stateNext = ST_ADD;
      ST_ADD:  stateNext = ST_LD;
      ST_LD:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.latchInstr = accept;
    ctl.latchIdx   = (state == ST_DEC);
    ctl.latchAddr  = (state == ST_ADR);
    ctl.latchData  = (state == ST_REQ) && memValid;
    ctl.latchPc    = (state == ST_ADD);
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_REQ);
  assign pcLoad = (state == ST_LD);
  assign done   = (state == ST_LD);

  p_load_ends_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);
  p_req_needs_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad && !done);

endmodule

// File: rtl/tblBranchDatapath.sv
module tblBranchDatapath
  import tblBranchPkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [REG_W-1:0]  regField,
  input  logic [XLEN-1:0]   idxVal,
  input  logic [HALF_W-1:0] memData,
  output logic [REG_W-1:0]  regSel,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   pcOut
);

  localparam int EXT_W = XLEN - HALF_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0]   baseQ;
  logic [XLEN-1:0]   idxQ;
  logic [XLEN-1:0]   addrQ;
  logic [HALF_W-1:0] offQ;
  logic [XLEN-1:0]   pcQ;
  logic [XLEN-1:0]   offExt;
  logic [REG_W-1:0]  regQ;

  assign offExt = {{EXT_W{offQ[HALF_W-1]}}, offQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      regQ  <= '0;
      idxQ  <= '0;
      addrQ <= '0;
      offQ  <= '0;
      pcQ   <= '0;
    end else begin
      if (ctl.latchInstr) begin
        baseQ <= pcIn + STEP;
        regQ  <= regField;
      end
      if (ctl.latchIdx)  idxQ  <= idxVal;
      if (ctl.latchAddr) addrQ <= baseQ + (idxQ << 1);
      if (ctl.latchData) offQ  <= memData;
      if (ctl.latchPc)   pcQ   <= baseQ + (offExt << 1);
    end
  end

  assign regSel  = regQ;
  assign memAddr = addrQ;
  assign pcOut   = pcQ;

endmodule

// File: rtl/tblBranchSeq.sv
module tblBranchSeq
  import tblBranchPkg::*;
#(
  parameter int XLEN    = 32,
  parameter int HALF_W  = 16,
  parameter int INSTR_W = 16,
  parameter int REG_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   idxVal,
  output logic [REG_W-1:0]  regSel,
  output logic              memReq,
  output logic [XLEN-1:0]   memAddr,
  input  logic              memValid,
  input  logic [HALF_W-1:0] memData,
  output logic              busy,
  output logic              pcLoad,
  output logic [XLEN-1:0]   pcOut,
  output logic              done
);

  localparam int OPC_W = INSTR_W - REG_W;
  localparam logic [OPC_W-1:0] OPC_PAT = OPC_W'(2);

  dpCtl_t ctl;

  tblBranchCtrl #(.OPC_W(OPC_W), .OPC_PAT(OPC_PAT)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcField (instrWord[INSTR_W-1:REG_W]),
    .memValid (memValid),
    .ctl      (ctl),
    .busy     (busy),
    .memReq   (memReq),
    .pcLoad   (pcLoad),
    .done     (done)
  );

  tblBranchDatapath #(.XLEN(XLEN), .HALF_W(HALF_W), .REG_W(REG_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pcIn     (pcIn),
    .regField (instrWord[REG_W-1:0]),
    .idxVal   (idxVal),
    .memData  (memData),
    .regSel   (regSel),
    .memAddr  (memAddr),
    .pcOut    (pcOut)
  );

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));
  p_regsel_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(regSel));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !pcLoad && !done);

endmodule

// File: tb/test_tblBranchSeq.sv
module test_tblBranchSeq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instrWord = '0;
  logic [31:0] pcIn = '0;
  logic [31:0] idxVal = '0;
  logic [4:0]  regSel;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [15:0] memData = '0;
  logic        busy;
  logic        pcLoad;
  logic [31:0] pcOut;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tblBranchSeq i_tblBranchSeq (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .pcIn(pcIn), .idxVal(idxVal), .regSel(regSel), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .busy(busy), .pcLoad(pcLoad), .pcOut(pcOut), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, memReq, pcLoad, done} == 4'b0, "R1", "reset outputs",
        {28'd0, busy, memReq, pcLoad, done}, 32'd0);
  endtask

  task automatic rejectWord(input logic [15:0] w);
    bit seen = 0;
    @(negedge clk);
    start = 1'b1; instrWord = w; pcIn = 32'h0000_2000;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (busy || memReq || pcLoad) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R2", "foreign opcode ignored", {31'd0, seen}, 32'd0);
  endtask

  task automatic runOp(input logic [4:0] rIdx, input logic [31:0] pc,
                       input logic [31:0] idx, input logic [15:0] data,
                       input int waits, input bit poke);
    logic [31:0] expAddr, expPc, firstAddr;
    int cnt = 0, wc = 0;
    bit reqSeen = 0, addrOk = 1, busyOk = 1, regOk = 1, loaded = 0;
    expAddr = pc + 32'd2 + (idx << 1);
    expPc   = pc + 32'd2 + ({{16{data[15]}}, data} << 1);
    firstAddr = '0;
    @(negedge clk);
    start = 1'b1; instrWord = {11'b00000000010, rIdx}; pcIn = pc; idxVal = idx;
    while (!loaded && cnt < 40) begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      memValid = 1'b0;
      if (poke && cnt == 2) begin
        start = 1'b1; instrWord = 16'h0047; pcIn = 32'h0;
      end
      if (!busy) busyOk = 0;
      if (regSel != rIdx) regOk = 0;
      if (memReq) begin
        if (!reqSeen) begin
          reqSeen = 1; firstAddr = memAddr;
          chk(memAddr == expAddr, "R3", "table address", memAddr, expAddr);
        end else if (memAddr != firstAddr) addrOk = 0;
        if (wc == waits) begin
          memValid = 1'b1; memData = data;
        end else wc++;
      end
      if (pcLoad) begin
        loaded = 1;
        chk(cnt == 5 + waits, "R5", "cycles to pcLoad", cnt, 5 + waits);
        chk(pcOut == expPc, "R4", "new pc", pcOut, expPc);
        chk(done, "R9", "done with pcLoad", {31'd0, done}, 32'd1);
      end
    end
    chk(loaded, "R5", "pcLoad seen", {31'd0, loaded}, 32'd1);
    chk(busyOk, "R6", "busy through op", {31'd0, busyOk}, 32'd1);
    chk(regOk, "R8", "regSel held", {27'd0, regSel}, {27'd0, rIdx});
    if (waits > 0)
      chk(addrOk, "R7", "address held over waits", memAddr, firstAddr);
    @(negedge clk);
    chk({busy, pcLoad, done} == 3'b0, "R9", "pulse ends, idle",
        {29'd0, busy, pcLoad, done}, 32'd0);
    if (poke)
      chk(!busy, "R6", "start while busy ignored", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checkReset();
    rejectWord(16'h0063);
    rejectWord(16'h0443);
    runOp(5'd3, 32'h0000_1000, 32'd3, 16'h0010, 0, 0);
    runOp(5'd9, 32'h0000_4000, 32'd1, 16'hFFF0, 0, 0);
    runOp(5'd31, 32'hFFFF_FFFE, 32'h8000_0001, 16'h8000, 1, 0);
    runOp(5'd12, 32'h0010_0020, 32'd100, 16'h7FFF, 3, 0);
    runOp(5'd4, 32'h0000_0800, 32'd2, 16'h0004, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule